// File: doc/BRIEF.md
# Inter-processor mailbox controller

This peripheral lets several processor channels trade short fixed-size messages and signal each other through interrupts. It contains a set of mailboxes. Each one holds seven 32-bit payload words, an owner bitmap that names the sending channel, a recipient bitmap, an interrupt-enable bitmap and a two-bit send state. Channels are identified by one-hot bit positions. The sender fills the payload and moves the send state to "posted", which raises an interrupt toward every recipient. A recipient answers by moving the state to "acknowledged", which turns the interrupt around toward the owner. Writing zero returns the mailbox to rest.

Software reaches the block over a plain synchronous register bus with word addresses. A write completes in the cycle it is presented. A read returns its data on `rdata` in the following cycle. The bus takes a request every cycle and has no back-pressure, so no ready signal exists. Each channel has one interrupt line plus two readable status words, one raw and one masked, in which bit m stands for mailbox m.

Top module: `ipcmb_top`

## Requirements
- R1: After reset, every stored register reads zero, every interrupt line is low and `rdata` is zero.
- R2: In the window of mailbox m (word base 16·m), writing a bitmap to word 1 ORs it into the recipient bitmap and writing to word 2 removes those bits. Word 3 reads the recipient bitmap. Words 5, 6 and 7 do the same for the interrupt-enable bitmap. A write to one mailbox leaves the others unchanged.
- R3: Word 0 stores the owner bitmap and word 4 stores a 32-bit mode value. Both read back as written, and the mode value never changes interrupt behaviour.
- R4: Words 9 to 15 of a mailbox window are its seven payload words, which any master can write and read back.
- R5: When the send state (word 8) is 1, raw status bit m is set for each channel in mailbox m's recipient bitmap.
- R6: When the send state is 2, raw status bit m is set for each channel in the owner bitmap and for no recipient.
- R7: The send state stores bits [1:0] of the written value and reads back as stored. States 0 and 3 set no raw status bit.
- R8: Masked status bit m of channel c is raw bit m of channel c ANDed with bit c of mailbox m's enable bitmap. Interrupt line c is the OR of channel c's masked bits.
- R9: Raw status for channel c is at word 0x201 + 2c and masked status is at word 0x200 + 2c. Unmapped words and the write-only set/clear words read zero. Writes to unmapped words and to status words change nothing.
- R10: `rdata` carries the addressed value exactly one cycle after `rd_en` and is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| irq | output | 8 | One interrupt line per channel |

## Verification
The bench builds the block with its defaults: four mailboxes, eight channels and seven payload words. With these values the top channel bit (7), the last status word (0x20F) and the unmapped gap between word 0x40 and word 0x200 can all be reached. Two mailboxes drive the same channel at once, so the masked-status OR and the clearing of a single enable bit while another mailbox is active are both exercised. The reserved send value 3 and an out-of-range write of 7 are also driven.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  localparam int BOX_WORDS = 16;
  localparam logic [3:0] OFF_OWNER = 4'd0;
  localparam logic [3:0] OFF_RSET  = 4'd1;
  localparam logic [3:0] OFF_RCLR  = 4'd2;
  localparam logic [3:0] OFF_RSTAT = 4'd3;
  localparam logic [3:0] OFF_MODE  = 4'd4;
  localparam logic [3:0] OFF_ESET  = 4'd5;
  localparam logic [3:0] OFF_ECLR  = 4'd6;
  localparam logic [3:0] OFF_ESTAT = 4'd7;
  localparam logic [3:0] OFF_SEND  = 4'd8;
  localparam int         OFF_DATA0 = 9;
  localparam logic [9:0] STAT_BASE = 10'h200;

  typedef enum logic [1:0] {
    SND_IDLE = 2'd0,
    SND_POST = 2'd1,
    SND_ACK  = 2'd2,
    SND_RSVD = 2'd3
  } snd_e;
endpackage

// File: rtl/ipcmb_box.sv
module ipcmb_box
  import ipcmb_pkg::*;
#(
  parameter int NUM_CHAN   = 8,
  parameter int DATA_WORDS = 7,
  parameter int MODE_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [3:0]          off,
  input  logic [31:0]         wdata,
  output logic [NUM_CHAN-1:0] owner_o,
  output logic [NUM_CHAN-1:0] rcpt_o,
  output logic [NUM_CHAN-1:0] enab_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [1:0]          send_o,
  output logic [31:0]         data_o [DATA_WORDS]
);
  logic [NUM_CHAN-1:0] wmap;
  assign wmap = wdata[NUM_CHAN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_o <= '0;
      rcpt_o  <= '0;
      enab_o  <= '0;
      mode_o  <= '0;
      send_o  <= SND_IDLE;
    end else if (we) begin
      case (off)
        OFF_OWNER: owner_o <= wmap;
        OFF_RSET:  rcpt_o  <= rcpt_o | wmap;
        OFF_RCLR:  rcpt_o  <= rcpt_o & ~wmap;
        OFF_MODE:  mode_o  <= wdata[MODE_W-1:0];
        OFF_ESET:  enab_o  <= enab_o | wmap;
        OFF_ECLR:  enab_o  <= enab_o & ~wmap;
        OFF_SEND:  send_o  <= wdata[1:0];
        default:   ;
      endcase
    end
  end

  for (genvar i = 0; i < DATA_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_o[i] <= '0;
      else if (we && off == 4'(OFF_DATA0 + i))
        data_o[i] <= wdata;
    end
  end
endmodule

// File: rtl/ipcmb_irq.sv
module ipcmb_irq
  import ipcmb_pkg::*;
#(
  parameter int NUM_BOX  = 4,
  parameter int NUM_CHAN = 8
) (
  input  logic [NUM_CHAN-1:0] owner_a [NUM_BOX],
  input  logic [NUM_CHAN-1:0] rcpt_a  [NUM_BOX],
  input  logic [NUM_CHAN-1:0] enab_a  [NUM_BOX],
  input  logic [1:0]          send_a  [NUM_BOX],
  output logic [NUM_BOX-1:0]  raw_a   [NUM_CHAN],
  output logic [NUM_BOX-1:0]  msk_a   [NUM_CHAN],
  output logic [NUM_CHAN-1:0] irq_o
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      assign raw_a[c][b] = ((send_a[b] == SND_POST) && rcpt_a[b][c]) ||
                           ((send_a[b] == SND_ACK)  && owner_a[b][c]);
      assign msk_a[c][b] = raw_a[c][b] && enab_a[b][c];
    end
    assign irq_o[c] = |msk_a[c];
  end
endmodule

// File: rtl/ipcmb_top.sv
module ipcmb_top
  import ipcmb_pkg::*;
#(
  parameter int NUM_BOX    = 4,
  parameter int NUM_CHAN   = 8,
  parameter int DATA_WORDS = 7,
  parameter int MODE_W     = 32,
  parameter int ADDR_W     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NUM_CHAN-1:0] irq
);
  localparam int BSW  = (NUM_BOX  > 1) ? $clog2(NUM_BOX)    : 1;
  localparam int CSW  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN)   : 1;
  localparam int DWW  = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam logic [ADDR_W-1:0] BOX_END  = ADDR_W'(NUM_BOX * BOX_WORDS);
  localparam logic [ADDR_W-1:0] STAT_END = ADDR_W'(STAT_BASE) + ADDR_W'(2 * NUM_CHAN);

  logic [NUM_CHAN-1:0] owner_a [NUM_BOX];
  logic [NUM_CHAN-1:0] rcpt_a  [NUM_BOX];
  logic [NUM_CHAN-1:0] enab_a  [NUM_BOX];
  logic [MODE_W-1:0]   mode_a  [NUM_BOX];
  logic [1:0]          send_a  [NUM_BOX];
  logic [31:0]         data_a  [NUM_BOX][DATA_WORDS];
  logic [NUM_BOX-1:0]  raw_a   [NUM_CHAN];
  logic [NUM_BOX-1:0]  msk_a   [NUM_CHAN];

  logic              in_box, in_stat;
  logic [BSW-1:0]    box_idx;
  logic [3:0]        off;
  logic [3:0]        didx;
  logic [ADDR_W-1:0] soff;
  logic [CSW-1:0]    ch_idx;
  logic [31:0]       rd_word;

  assign in_box  = addr < BOX_END;
  assign in_stat = (addr >= ADDR_W'(STAT_BASE)) && (addr < STAT_END);
  assign box_idx = addr[4 +: BSW];
  assign off     = addr[3:0];
  assign didx    = off - 4'(OFF_DATA0);
  assign soff    = addr - ADDR_W'(STAT_BASE);
  assign ch_idx  = soff[CSW:1];

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    logic box_we;
    assign box_we = wr_en && in_box && (box_idx == BSW'(b));
    ipcmb_box #(
      .NUM_CHAN  (NUM_CHAN),
      .DATA_WORDS(DATA_WORDS),
      .MODE_W    (MODE_W)
    ) u_box (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (box_we),
      .off    (off),
      .wdata  (wdata),
      .owner_o(owner_a[b]),
      .rcpt_o (rcpt_a[b]),
      .enab_o (enab_a[b]),
      .mode_o (mode_a[b]),
      .send_o (send_a[b]),
      .data_o (data_a[b])
    );
  end

  ipcmb_irq #(
    .NUM_BOX (NUM_BOX),
    .NUM_CHAN(NUM_CHAN)
  ) u_irq (
    .owner_a(owner_a),
    .rcpt_a (rcpt_a),
    .enab_a (enab_a),
    .send_a (send_a),
    .raw_a  (raw_a),
    .msk_a  (msk_a),
    .irq_o  (irq)
  );

  always_comb begin
    rd_word = '0;
    if (in_box) begin
      case (off)
        OFF_OWNER: rd_word = 32'(owner_a[box_idx]);
        OFF_RSTAT: rd_word = 32'(rcpt_a[box_idx]);
        OFF_MODE:  rd_word = 32'(mode_a[box_idx]);
        OFF_ESTAT: rd_word = 32'(enab_a[box_idx]);
        OFF_SEND:  rd_word = 32'(send_a[box_idx]);
        default: begin
          if (off >= 4'(OFF_DATA0) && didx < 4'(DATA_WORDS))
            rd_word = data_a[box_idx][didx[DWW-1:0]];
        end
      endcase
    end else if (in_stat) begin
      rd_word = soff[0] ? 32'(raw_a[ch_idx]) : 32'(msk_a[ch_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_word : '0;
  end
endmodule

// File: rtl/ipcmb_checker.sv
module ipcmb_checker #(
  parameter int NUM_BOX  = 4,
  parameter int NUM_CHAN = 8,
  parameter int MODE_W   = 32,
  parameter int ADDR_W   = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic [NUM_CHAN-1:0] irq,
  input logic [NUM_CHAN-1:0] owner_a [NUM_BOX],
  input logic [NUM_CHAN-1:0] rcpt_a  [NUM_BOX],
  input logic [NUM_CHAN-1:0] enab_a  [NUM_BOX],
  input logic [MODE_W-1:0]   mode_a  [NUM_BOX],
  input logic [1:0]          send_a  [NUM_BOX]
);
  logic                mapped;
  logic                all_quiet;
  logic [NUM_CHAN-1:0] any_enab;

  assign mapped = (addr < ADDR_W'(NUM_BOX * 16)) ||
                  ((addr >= ADDR_W'(10'h200)) && (addr < ADDR_W'(10'h200 + 2 * NUM_CHAN)));

  always_comb begin
    all_quiet = 1'b1;
    any_enab  = '0;
    for (int b = 0; b < NUM_BOX; b++) begin
      if (send_a[b] == 2'd1 || send_a[b] == 2'd2) all_quiet = 1'b0;
      any_enab = any_enab | enab_a[b];
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    all_quiet |-> irq == '0); // R7

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> rdata == '0); // R10

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_c
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> any_enab[c]); // R8
    for (genvar b = 0; b < NUM_BOX; b++) begin : g_b
      AST_POST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (send_a[b] == 2'd1 && rcpt_a[b][c] && enab_a[b][c]) |-> irq[c]); // R5
      AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (send_a[b] == 2'd2 && owner_a[b][c] && enab_a[b][c]) |-> irq[c]); // R6
    end
  end

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_w
    AST_RSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(b * 16 + 1)) |=>
        ((rcpt_a[b] & $past(wdata[NUM_CHAN-1:0])) == $past(wdata[NUM_CHAN-1:0]))); // R2
    AST_RCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(b * 16 + 2)) |=>
        ((rcpt_a[b] & $past(wdata[NUM_CHAN-1:0])) == '0)); // R2
    AST_ECLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(b * 16 + 6)) |=>
        ((enab_a[b] & $past(wdata[NUM_CHAN-1:0])) == '0)); // R2
    AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> ($stable(owner_a[b]) && $stable(rcpt_a[b]) &&
        $stable(enab_a[b]) && $stable(mode_a[b]) && $stable(send_a[b]))); // R9
  end
endmodule

bind ipcmb_top ipcmb_checker #(
  .NUM_BOX (NUM_BOX),
  .NUM_CHAN(NUM_CHAN),
  .MODE_W  (MODE_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .irq    (irq),
  .owner_a(owner_a),
  .rcpt_a (rcpt_a),
  .enab_a (enab_a),
  .mode_a (mode_a),
  .send_a (send_a)
);

// File: tb/ipcmb_top_bench.sv
module ipcmb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ipcmb_top u_ipcmb_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [9:0] bx(int b, int off);
    return 10'(b * 16 + off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(logic [7:0] exp, string tag);
    @(negedge clk);
    check(tag, 32'(irq), 32'(exp));
  endtask

  // monitor: pops one expectation per read and compares one cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("monitor-empty", rdata, 32'hx);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(8'h00, "R1 irq after reset");
    check("R1 rdata after reset", rdata, 32'h0);
    rd(bx(0, 3), 32'h0, "R1 recipients zero");
    rd(bx(3, 8), 32'h0, "R1 send zero");
    rd(bx(2, 15), 32'h0, "R1 last data word zero");

    // R2 set/clear bitmaps
    wr(bx(0, 1), 32'h05);
    wr(bx(0, 1), 32'h80);
    rd(bx(0, 3), 32'h85, "R2 recipient OR");
    wr(bx(0, 2), 32'h04);
    rd(bx(0, 3), 32'h81, "R2 recipient clear");
    wr(bx(0, 5), 32'h03);
    rd(bx(0, 7), 32'h03, "R2 enable set");
    rd(bx(1, 3), 32'h00, "R2 other box untouched");

    // R3 owner and mode
    wr(bx(0, 0), 32'h02);
    rd(bx(0, 0), 32'h02, "R3 owner readback");
    wr(bx(0, 4), 32'hA5A5_0001);
    rd(bx(0, 4), 32'hA5A5_0001, "R3 mode readback");
    chk_irq(8'h00, "R3 mode has no effect");

    // R4 payload
    for (int i = 0; i < 7; i++) wr(bx(2, 9 + i), 32'h1000 + 32'(i * 3));
    for (int i = 0; i < 7; i++) rd(bx(2, 9 + i), 32'h1000 + 32'(i * 3), "R4 payload word");
    rd(bx(3, 9), 32'h0, "R4 other box payload");

    // R5 post
    wr(bx(0, 8), 32'h1);
    chk_irq(8'h01, "R5 post irq");
    rd(10'h20F, 32'h1, "R5 raw ch7");
    rd(10'h20E, 32'h0, "R8 masked ch7");
    rd(10'h200, 32'h1, "R8 masked ch0");

    // R6 acknowledge
    wr(bx(0, 8), 32'h2);
    chk_irq(8'h02, "R6 ack irq");
    rd(10'h203, 32'h1, "R6 raw ch1");
    rd(10'h201, 32'h0, "R6 raw ch0 dropped");
    rd(bx(0, 8), 32'h2, "R7 send readback");

    // R7 idle and reserved
    wr(bx(0, 8), 32'h0);
    chk_irq(8'h00, "R7 idle irq");
    rd(10'h20F, 32'h0, "R7 raw ch7 idle");
    wr(bx(0, 8), 32'h7);
    rd(bx(0, 8), 32'h3, "R7 stores low bits");
    chk_irq(8'h00, "R7 reserved irq");
    rd(10'h203, 32'h0, "R7 reserved raw");

    // R8 two boxes on one channel
    wr(bx(0, 8), 32'h1);
    wr(bx(1, 1), 32'h01);
    wr(bx(1, 5), 32'h01);
    wr(bx(1, 8), 32'h1);
    rd(10'h201, 32'h3, "R8 raw ch0 two boxes");
    rd(10'h200, 32'h3, "R8 masked ch0 two boxes");
    wr(bx(0, 6), 32'h01);
    rd(10'h200, 32'h2, "R8 masked after enable clear");
    rd(10'h201, 32'h3, "R8 raw unaffected by enable");
    chk_irq(8'h01, "R8 irq still from box1");
    wr(bx(1, 8), 32'h0);
    chk_irq(8'h00, "R8 irq low");

    // R9 unmapped
    wr(10'h100, 32'hFFFF_FFFF);
    wr(10'h210, 32'hFFFF_FFFF);
    wr(10'h200, 32'hFFFF_FFFF);
    rd(10'h100, 32'h0, "R9 gap reads zero");
    rd(10'h210, 32'h0, "R9 past status zero");
    rd(bx(0, 1), 32'h0, "R9 set word reads zero");
    rd(bx(0, 3), 32'h81, "R9 recipients kept");
    rd(bx(0, 7), 32'h02, "R9 enable kept");
    rd(bx(0, 8), 32'h1, "R9 send kept");

    // R10 idle rdata
    repeat (2) @(negedge clk);
    check("R10 rdata idle", rdata, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule